// File: doc/BRIEF.md
# Complementary PWM Dead-Time Generator

This block sits behind a timer's compare unit. It turns one waveform bit into a true output and a complementary output for a pair of pads. In the complementary configuration (PWM operation with the output-mode field at 2'b01), it holds both outputs low for a programmable non-overlap gap before either one rises. The gap before the true output rises and the gap before the complementary output rises are set separately. Each gap is counted in ticks of a prescaled dead-time clock.

In every other configuration, the block only re-times the waveform by one clock, as a synchronizer. The true output then follows the waveform and the complementary output follows its inverse. Whenever the output-mode field is non-zero, the generated values replace the general-purpose port value. A per-pad direction bit still decides whether the value reaches the pad.

Top module: `cpwm_deadtime`

## Requirements
- R1: While `rst` is high at a clock edge, both internal output states are cleared to 0. From the next sampling point on, `pad_true` and `pad_comp` read 0.
- R2: When `pwm_en` is 0, the true state takes the value `wave_in` had at the previous clock edge, and the complementary state takes its inverse (one-clock synchronizer).
- R3: Dead-time insertion is active only when `pwm_en` is 1 and `cmp_mode` equals 2'b01. With `pwm_en` at 1 and any other `cmp_mode` value, the behaviour of R2 applies.
- R4: In dead-time mode, a rising edge of `wave_in` is seen at a clock edge. At that edge both states go low and the gap counter loads `dt_gap[7:4]`. The true state rises at the clock edge on which a tick takes the counter from 1 to 0.
- R5: A falling edge of `wave_in` in dead-time mode mirrors R4. The counter loads `dt_gap[3:0]` and the complementary state rises when that count expires.
- R6: `dt_presc` values 0, 1, 2 and 3 give tick periods of 1, 2, 4 and 8 clocks. A free-running 3-bit counter is cleared by reset and advances every clock. A tick occurs at an edge where its low `dt_presc` bits are all zero.
- R7: If `wave_in` reverses before a pending count expires, the count restarts with the nibble for the new direction. The output that was waiting to rise stays low.
- R8: A gap nibble of 0 makes the corresponding output rise at the same edge that sees the waveform change, so there is no delay beyond one clock.
- R9: The true and complementary states are never both 1 in the same cycle, in any mode.
- R10: `ovr_true` and `ovr_comp` are 1 exactly when `cmp_mode` is non-zero. `pad_true` equals the true state AND `ovr_true` AND `dir_true`, and `pad_comp` is formed the same way from the complementary state, `ovr_comp` and `dir_comp`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| wave_in | input | 1 | Waveform bit from the compare unit |
| cmp_mode | input | 2 | Output-mode field; 2'b01 selects the complementary pair in PWM operation |
| pwm_en | input | 1 | High while the timer runs a PWM mode |
| dt_presc | input | 2 | Dead-time prescaler select (divide by 1, 2, 4, 8) |
| dt_gap | input | 8 | Upper nibble: gap before true rise; lower nibble: gap before complement rise |
| dir_true | input | 1 | Direction bit of the true pad (1 = output) |
| dir_comp | input | 1 | Direction bit of the complementary pad (1 = output) |
| pad_true | output | 1 | Value driven to the true pad |
| pad_comp | output | 1 | Value driven to the complementary pad |
| ovr_true | output | 1 | Port override enable for the true pad |
| ovr_comp | output | 1 | Port override enable for the complementary pad |

## Verification
The hardest case to reach is a waveform reversal that lands partway through a long, slowly ticking gap. It needs a large nibble, a coarse prescaler and an edge that arrives a few clocks after the previous one. The stimulus sets both nibbles to 15 with divide-by-4 and pulses the waveform high and low for three clocks each before letting it settle. A behavioural model tracks the free-running prescaler phase, so the exact edge at which the waiting output rises is predicted on every clock.

// File: rtl/cpwm_deadtime_pkg.sv
package cpwm_deadtime_pkg;

    typedef enum logic [1:0] {
        OM_PORT  = 2'b00,
        OM_COMPL = 2'b01,
        OM_ALT2  = 2'b10,
        OM_ALT3  = 2'b11
    } out_mode_e;

    typedef struct packed {
        logic pos;
        logic neg;
    } out_pair_t;

    // Tick mask: low 'sel' bits set.
    function automatic logic [6:0] presc_mask(input logic [2:0] sel);
        logic [6:0] m;
        for (int i = 0; i < 7; i++) begin
            m[i] = (i < int'(sel));
        end
        return m;
    endfunction

endpackage

// File: rtl/cpwm_presc.sv
module cpwm_presc
    import cpwm_deadtime_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CW = (1 << SEL_W) - 1;

    logic [CW-1:0] phase;
    logic [CW-1:0] mask;

    always_comb begin
        for (int i = 0; i < CW; i++) begin
            mask[i] = (i < int'(sel));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    assign tick = ((phase & mask) == '0);

endmodule

// File: rtl/cpwm_gap_core.sv
module cpwm_gap_core
    import cpwm_deadtime_pkg::*;
#(
    parameter int GAP_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wave,
    input  logic             dt_on,
    input  logic             tick,
    input  logic [GAP_W-1:0] gap_to_true,
    input  logic [GAP_W-1:0] gap_to_comp,
    output out_pair_t        oc
);
    logic             wave_q;
    logic [GAP_W-1:0] remain;
    logic [GAP_W-1:0] load_val;
    logic             edge_seen;

    assign edge_seen = (wave != wave_q);

    always_comb begin
        load_val = wave ? gap_to_true : gap_to_comp;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wave_q <= 1'b0;
            remain <= '0;
            oc     <= '0;
        end else if (!dt_on) begin
            wave_q <= wave;
            remain <= '0;
            oc.pos <= wave;
            oc.neg <= ~wave;
        end else if (edge_seen) begin
            wave_q <= wave;
            remain <= load_val;
            if (load_val == '0) begin
                oc.pos <= wave;
                oc.neg <= ~wave;
            end else begin
                oc <= '0;
            end
        end else if (remain != '0) begin
            if (tick) begin
                remain <= remain - 1'b1;
                if (remain == GAP_W'(1)) begin
                    oc.pos <= wave_q;
                    oc.neg <= ~wave_q;
                end
            end
        end else begin
            oc.pos <= wave_q;
            oc.neg <= ~wave_q;
        end
    end

endmodule

// File: rtl/cpwm_pad_mux.sv
module cpwm_pad_mux
    import cpwm_deadtime_pkg::*;
#(
    parameter int NPADS = 2
) (
    input  logic [NPADS-1:0] src,
    input  logic [NPADS-1:0] dir,
    input  logic [1:0]       mode,
    output logic [NPADS-1:0] pad,
    output logic [NPADS-1:0] ovr
);
    for (genvar g = 0; g < NPADS; g++) begin : g_pad
        assign ovr[g] = (mode != OM_PORT);
        assign pad[g] = src[g] & ovr[g] & dir[g];
    end

endmodule

// File: rtl/cpwm_deadtime.sv
module cpwm_deadtime
    import cpwm_deadtime_pkg::*;
#(
    parameter int GAP_W = 4,
    parameter int SEL_W = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wave_in,
    input  logic [1:0]         cmp_mode,
    input  logic               pwm_en,
    input  logic [SEL_W-1:0]   dt_presc,
    input  logic [2*GAP_W-1:0] dt_gap,
    input  logic               dir_true,
    input  logic               dir_comp,
    output logic               pad_true,
    output logic               pad_comp,
    output logic               ovr_true,
    output logic               ovr_comp
);
    logic      tick;
    logic      dt_on;
    out_pair_t oc;
    logic      oc_true;
    logic      oc_comp;
    logic [1:0] pads;
    logic [1:0] ovrs;

    assign dt_on   = pwm_en && (cmp_mode == OM_COMPL);
    assign oc_true = oc.pos;
    assign oc_comp = oc.neg;

    cpwm_presc #(.SEL_W(SEL_W)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .sel  (dt_presc),
        .tick (tick)
    );

    cpwm_gap_core #(.GAP_W(GAP_W)) u_core (
        .clk         (clk),
        .rst         (rst),
        .wave        (wave_in),
        .dt_on       (dt_on),
        .tick        (tick),
        .gap_to_true (dt_gap[2*GAP_W-1:GAP_W]),
        .gap_to_comp (dt_gap[GAP_W-1:0]),
        .oc          (oc)
    );

    cpwm_pad_mux #(.NPADS(2)) u_mux (
        .src  ({oc_comp, oc_true}),
        .dir  ({dir_comp, dir_true}),
        .mode (cmp_mode),
        .pad  (pads),
        .ovr  (ovrs)
    );

    assign pad_true = pads[0];
    assign pad_comp = pads[1];
    assign ovr_true = ovrs[0];
    assign ovr_comp = ovrs[1];

endmodule

// File: rtl/cpwm_deadtime_chk.sv
module cpwm_deadtime_chk (
    input logic       clk,
    input logic       rst,
    input logic       wave_in,
    input logic       dt_on,
    input logic [1:0] cmp_mode,
    input logic       dir_true,
    input logic       dir_comp,
    input logic       oc_true,
    input logic       oc_comp,
    input logic       pad_true,
    input logic       pad_comp
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!oc_true && !oc_comp));

    // R2
    sync_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !dt_on |=> (oc_true == $past(wave_in)) && (oc_comp != $past(wave_in)));

    // R4
    comp_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (dt_on && wave_in) |=> !oc_comp);

    // R5
    true_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (dt_on && !wave_in) |=> !oc_true);

    // R9
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !(oc_true && oc_comp));

    // R10
    pad_gate_true_chk: assert property (@(posedge clk) disable iff (rst)
        pad_true |-> (dir_true && cmp_mode != 2'b00 && oc_true));

    // R10
    pad_gate_comp_chk: assert property (@(posedge clk) disable iff (rst)
        pad_comp |-> (dir_comp && cmp_mode != 2'b00 && oc_comp));

endmodule

bind cpwm_deadtime cpwm_deadtime_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .wave_in  (wave_in),
    .dt_on    (dt_on),
    .cmp_mode (cmp_mode),
    .dir_true (dir_true),
    .dir_comp (dir_comp),
    .oc_true  (oc_true),
    .oc_comp  (oc_comp),
    .pad_true (pad_true),
    .pad_comp (pad_comp)
);

// File: tb/cpwm_deadtime_test.sv
module cpwm_deadtime_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wave_in = 1'b0;
    logic [1:0] cmp_mode = 2'b01;
    logic       pwm_en = 1'b1;
    logic [1:0] dt_presc = 2'b00;
    logic [7:0] dt_gap = 8'h00;
    logic       dir_true = 1'b1;
    logic       dir_comp = 1'b1;
    logic       pad_true, pad_comp, ovr_true, ovr_comp;

    int checks = 0;
    int fails  = 0;

    // behavioural reference state
    int m_true = 0, m_comp = 0, m_level = 0, m_wait = 0, m_phase = 0;

    always #4 clk = ~clk;

    cpwm_deadtime uut (
        .clk      (clk),
        .rst      (rst),
        .wave_in  (wave_in),
        .cmp_mode (cmp_mode),
        .pwm_en   (pwm_en),
        .dt_presc (dt_presc),
        .dt_gap   (dt_gap),
        .dir_true (dir_true),
        .dir_comp (dir_comp),
        .pad_true (pad_true),
        .pad_comp (pad_comp),
        .ovr_true (ovr_true),
        .ovr_comp (ovr_comp)
    );

    always @(posedge clk) begin
        int w, div, ticked, gap;
        w = int'(wave_in);
        if (rst) begin
            m_true = 0; m_comp = 0; m_level = 0; m_wait = 0; m_phase = 0;
        end else begin
            div = 1 << dt_presc;
            ticked = ((m_phase % div) == 0);
            m_phase = (m_phase + 1) % 8;
            if (!(pwm_en && cmp_mode == 2'b01)) begin
                m_level = w; m_wait = 0; m_true = w; m_comp = 1 - w;
            end else if (w != m_level) begin
                m_level = w;
                gap = w ? int'(dt_gap[7:4]) : int'(dt_gap[3:0]);
                m_wait = gap;
                m_true = 0; m_comp = 0;
                if (gap == 0) begin m_true = w; m_comp = 1 - w; end
            end else if (m_wait > 0) begin
                if (ticked) begin
                    m_wait--;
                    if (m_wait == 0) begin m_true = m_level; m_comp = 1 - m_level; end
                end
            end else begin
                m_true = m_level; m_comp = 1 - m_level;
            end
        end
    end

    task automatic check1(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare(input string tag);
        int ov, et, ec;
        ov = (cmp_mode != 2'b00);
        et = m_true & ov & int'(dir_true);
        ec = m_comp & ov & int'(dir_comp);
        check1(tag, "pad_true", int'(pad_true), et);
        check1(tag, "pad_comp", int'(pad_comp), ec);
        check1("R10", "ovr_true", int'(ovr_true), ov);
        check1("R10", "ovr_comp", int'(ovr_comp), ov);
        check1("R9", "overlap", int'(pad_true & pad_comp), 0);
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare(tag);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        run(3, "R1");
        rst = 1'b0;
        dt_gap = 8'h35;
        run(4, "R1");

        // R2: non-PWM synchronizer, several patterns
        pwm_en = 1'b0; cmp_mode = 2'b10;
        for (int i = 0; i < 24; i++) begin
            wave_in = (i % 3 == 0) || (i % 5 == 1);
            run(1, "R2");
        end

        // R3: PWM with non-complementary modes behaves as synchronizer
        pwm_en = 1'b1;
        for (int mv = 2; mv < 4; mv++) begin
            cmp_mode = 2'(mv);
            for (int i = 0; i < 12; i++) begin
                wave_in = i[1];
                run(1, "R3");
            end
        end

        // R4 / R5: complementary mode with distinct nibbles
        cmp_mode = 2'b01; dt_presc = 2'd0; dt_gap = 8'h53;
        wave_in = 1'b0; run(10, "R5");
        wave_in = 1'b1; run(12, "R4");
        wave_in = 1'b0; run(12, "R5");
        dt_gap = 8'h2A;
        wave_in = 1'b1; run(14, "R4");
        wave_in = 1'b0; run(14, "R5");

        // R6: each prescaler setting
        dt_gap = 8'h34;
        for (int s = 0; s < 4; s++) begin
            dt_presc = 2'(s);
            wave_in = 1'b1; run(40, "R6");
            wave_in = 1'b0; run(40, "R6");
        end

        // R7: reversal during a long gap
        dt_gap = 8'hFF; dt_presc = 2'd2;
        wave_in = 1'b1; run(3, "R7");
        wave_in = 1'b0; run(3, "R7");
        wave_in = 1'b1; run(70, "R7");
        wave_in = 1'b0; run(5, "R7");
        wave_in = 1'b1; run(2, "R7");
        wave_in = 1'b0; run(70, "R7");

        // R8: zero gap in either direction
        dt_gap = 8'h00; dt_presc = 2'd3;
        for (int i = 0; i < 10; i++) begin
            wave_in = i[0];
            run(2, "R8");
        end
        dt_gap = 8'h07;
        wave_in = 1'b1; run(3, "R8");
        wave_in = 1'b0; run(70, "R8");

        // R10: override and direction gating
        dt_gap = 8'h11; dt_presc = 2'd0;
        dir_true = 1'b0;
        wave_in = 1'b1; run(6, "R10");
        wave_in = 1'b0; run(6, "R10");
        dir_true = 1'b1; dir_comp = 1'b0;
        wave_in = 1'b1; run(6, "R10");
        wave_in = 1'b0; run(6, "R10");
        dir_comp = 1'b1; cmp_mode = 2'b00;
        wave_in = 1'b1; run(6, "R10");
        wave_in = 1'b0; run(6, "R10");

        // R1: reset in the middle of a pending gap
        cmp_mode = 2'b01; dt_gap = 8'hF0; dt_presc = 2'd1;
        wave_in = 1'b1; run(4, "R1");
        rst = 1'b1; run(2, "R1");
        rst = 1'b0; run(40, "R1");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule